// File: doc/BRIEF.md
# Odd-Byte Residue Packer for a 16-bit Receive Path

This block takes a byte-wide receive stream and packs it into 16-bit words for a wide data path. Bytes arrive one per valid cycle. The first byte of each pair goes into the low lane and the second into the high lane, and each complete word leaves one clock after its second byte.

A transfer may end on an odd byte while it is receiving and while the residue-holding enable is set. In that case the last byte is not padded. The block keeps it in a residue register and raises a flag. The first byte of the next transfer completes the word: the kept byte goes in the low lane and the new byte in the high lane. Pairing in that next transfer is therefore shifted by one byte.

A transfer can also end on an odd byte while sending, or while the enable is clear. In those cases the last byte leaves at once as a half word with only the low byte-enable set. A flush pulse releases a kept residue byte in the same half-word form.

Top module: `wide_residue_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `out_be` is 2'b00 and `res_held` is 0.
- R2: Within a transfer, two consecutive bytes produce one word one cycle after the second byte. The first byte is in bits [7:0], the second in bits [15:8], and `out_be` is 2'b11.
- R3: When `hold_en`=1 and `rx_dir`=1 (receive), a last byte that arrives with no low byte pending produces no output, and `res_held` is 1 on the next cycle.
- R4: While `res_held`=1, the next valid byte produces the word {new byte, residue byte} with `out_be`=2'b11 one cycle later, and `res_held` returns to 0.
- R5: After a merge, the remaining bytes of that transfer pair from the byte that follows the merging byte.
- R6: When `hold_en`=0, a last byte with no low byte pending leaves as {8'h00, byte} with `out_be`=2'b01, and `res_held` stays 0.
- R7: When `rx_dir`=0 (send), a last byte with no low byte pending leaves as {8'h00, byte} with `out_be`=2'b01, even when `hold_en`=1.
- R8: A `flush` pulse in a cycle without `in_valid` while `res_held`=1 emits {8'h00, residue} with `out_be`=2'b01 one cycle later, and clears `res_held`.
- R9: A `flush` pulse while no residue is held produces no output.
- R10: `out_be` is 2'b00 whenever `out_valid` is 0, and is 2'b01 or 2'b11 whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte is the last of its transfer |
| rx_dir | input | 1 | 1 = receive, 0 = send |
| hold_en | input | 1 | Enables keeping an odd trailing byte on receive |
| flush | input | 1 | Release a held residue byte as a half word |
| out_valid | output | 1 | Output word present |
| out_data | output | 16 | Output word, low lane in [7:0] |
| out_be | output | 2 | Byte enables, bit 0 for the low lane |
| res_held | output | 1 | A residue byte is kept across a transfer boundary |

## Verification
The assertions assume that the controls are known after reset. They also assume that `flush` is only meaningful in a cycle without `in_valid`, because a byte takes precedence over a flush in the same cycle.

The properties also treat `rx_dir` and `hold_en` as fixed for the length of a transfer. The bench changes those settings only between transfers, while no low byte is pending. It raises `flush` only in idle cycles, both with and without a held residue.

// File: rtl/wide_residue_packer.sv
module wide_residue_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        rx_dir,
  input  logic        hold_en,
  input  logic        flush,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic [1:0]  out_be,
  output logic        res_held
);

  logic [7:0] lo_byte;
  logic       lo_v;
  logic       carry;

  wire keep_odd = hold_en & rx_dir;

  assign res_held = lo_v & carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_byte   <= '0;
      lo_v      <= 1'b0;
      carry     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= 2'b00;
    end else begin
      out_valid <= 1'b0;
      out_be    <= 2'b00;
      if (in_valid) begin
        if (lo_v) begin
          out_valid <= 1'b1;
          out_data  <= {in_data, lo_byte};
          out_be    <= 2'b11;
          lo_v      <= 1'b0;
          carry     <= 1'b0;
        end else if (in_last && !keep_odd) begin
          out_valid <= 1'b1;
          out_data  <= {8'h00, in_data};
          out_be    <= 2'b01;
        end else begin
          lo_byte <= in_data;
          lo_v    <= 1'b1;
          carry   <= in_last;
        end
      end else if (flush && lo_v && carry) begin
        out_valid <= 1'b1;
        out_data  <= {8'h00, lo_byte};
        out_be    <= 2'b01;
        lo_v      <= 1'b0;
        carry     <= 1'b0;
      end
    end
  end

  assert_be_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_be == 2'b11 || out_be == 2'b01));

  assert_be_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_be == 2'b00);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && hold_en && rx_dir && !lo_v) |=> (res_held && !out_valid));

  assert_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_held && in_valid) |=> (out_valid && out_be == 2'b11 && !res_held &&
                                out_data[15:8] == $past(in_data)));

  assert_nohold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !hold_en && !lo_v) |=> (out_valid && out_be == 2'b01 && !res_held));

  assert_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !rx_dir && !lo_v) |=> (out_valid && out_be == 2'b01));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_held && flush && !in_valid) |=> (out_valid && out_be == 2'b01 && !res_held));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_v && flush && !in_valid) |=> !out_valid);

endmodule

// File: tb/tb_wide_residue_packer.sv
module tb_wide_residue_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        rx_dir = 1'b1;
  logic        hold_en = 1'b1;
  logic        flush = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_be;
  logic        res_held;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  wide_residue_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .rx_dir(rx_dir), .hold_en(hold_en), .flush(flush),
    .out_valid(out_valid), .out_data(out_data), .out_be(out_be), .res_held(res_held)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change 1 ns after a rising edge; outputs are read 1 ns after the next one.
  task automatic step(input logic v, input logic [7:0] d, input logic last, input logic fl);
    in_valid = v; in_data = d; in_last = last; flush = fl;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; flush = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [15:0] d, input logic [1:0] be);
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, {16'd0, out_data}, {16'd0, d});
    chk(req, {30'd0, out_be}, {30'd0, be});
  endtask

  task automatic expect_none(input string req);
    chk(req, {31'd0, out_valid}, 32'd0);
    chk(req, {30'd0, out_be}, 32'd0);
  endtask

  task automatic t_reset;
    expect_none("R1");
    chk("R1", {31'd0, res_held}, 32'd0);
  endtask

  task automatic t_pair;
    rx_dir = 1'b1; hold_en = 1'b1;
    step(1'b1, 8'hA1, 1'b0, 1'b0); expect_none("R2");
    step(1'b1, 8'hA2, 1'b1, 1'b0); expect_word("R2", 16'hA2A1, 2'b11);
    chk("R2", {31'd0, res_held}, 32'd0);
  endtask

  task automatic t_hold_merge;
    rx_dir = 1'b1; hold_en = 1'b1;
    step(1'b1, 8'hB1, 1'b0, 1'b0);
    step(1'b1, 8'hB2, 1'b0, 1'b0); expect_word("R2", 16'hB2B1, 2'b11);
    step(1'b1, 8'hB3, 1'b1, 1'b0); expect_none("R3");
    chk("R3", {31'd0, res_held}, 32'd1);
    step(1'b0, 8'h00, 1'b0, 1'b0); expect_none("R3");
    chk("R3", {31'd0, res_held}, 32'd1);
    step(1'b1, 8'hC1, 1'b0, 1'b0); expect_word("R4", 16'hC1B3, 2'b11);
    chk("R4", {31'd0, res_held}, 32'd0);
    step(1'b1, 8'hC2, 1'b0, 1'b0); expect_none("R5");
    step(1'b1, 8'hC3, 1'b1, 1'b0); expect_word("R5", 16'hC3C2, 2'b11);
    chk("R5", {31'd0, res_held}, 32'd0);
  endtask

  task automatic t_nohold;
    rx_dir = 1'b1; hold_en = 1'b0;
    step(1'b1, 8'hD1, 1'b1, 1'b0); expect_word("R6", 16'h00D1, 2'b01);
    chk("R6", {31'd0, res_held}, 32'd0);
    hold_en = 1'b1;
  endtask

  task automatic t_send;
    rx_dir = 1'b0; hold_en = 1'b1;
    step(1'b1, 8'hE0, 1'b0, 1'b0);
    step(1'b1, 8'hE1, 1'b0, 1'b0); expect_word("R7", 16'hE1E0, 2'b11);
    step(1'b1, 8'hE2, 1'b1, 1'b0); expect_word("R7", 16'h00E2, 2'b01);
    chk("R7", {31'd0, res_held}, 32'd0);
    rx_dir = 1'b1;
  endtask

  task automatic t_flush;
    rx_dir = 1'b1; hold_en = 1'b1;
    step(1'b1, 8'hF1, 1'b1, 1'b0); expect_none("R8");
    chk("R8", {31'd0, res_held}, 32'd1);
    step(1'b0, 8'h00, 1'b0, 1'b1); expect_word("R8", 16'h00F1, 2'b01);
    chk("R8", {31'd0, res_held}, 32'd0);
  endtask

  task automatic t_flush_empty;
    step(1'b0, 8'h00, 1'b0, 1'b1); expect_none("R9");
    step(1'b0, 8'h00, 1'b0, 1'b0); expect_none("R10");
    chk("R9", {31'd0, res_held}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_pair();
    t_hold_merge();
    t_nohold();
    t_send();
    t_flush();
    t_flush_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule